// File: doc/BRIEF.md
# Frequency-Hopped Chip Sequencer

This block produces the control words for a stepped-frequency pulse made of a train of chips. It is meant to sit in front of a phase-accumulator oscillator. A start strobe begins a pulse. The block then counts a configured number of chips, and each chip lasts a configured number of samples. For every chip it presents a frequency increment word equal to a base frequency plus the chip's slot number times a step. The oscillator adds that increment to a 32-bit phase accumulator each sample, and one full wrap of the accumulator is one output cycle.

The slot numbers are not used in ascending order. A seeded maximal-length shift register shuffles them, so that every slot is used exactly once in each group of 2^SLOT_BITS chips. Phase normally runs on across chip boundaries: the start-phase word is loaded only at the first chip. An optional mode reloads it at every chip boundary. All configuration arrives on plain input ports and is captured when a pulse starts.

Top module: `chip_hop_sequencer`

## Requirements
- R1: While rst_n is low and at the first clock after it rises, freq_word_o, phase_word_o, chip_index_o, chip_valid_o, chip_first_o, phase_load_o and pulse_done_o are all zero.
- R2: When start_i is sampled high with a valid configuration, the next cycle shows the following: chip_valid_o=1, chip_first_o=1, chip_index_o=0, phase_load_o=1, freq_word_o equal to base_freq_i, and phase_word_o equal to start_phase_i.
- R3: The configuration word cfg_chips_i holds the chip count N in bits [31:16] and the samples per chip S in bits [15:0]. A pulse raises chip_valid_o for exactly N*S consecutive cycles. chip_index_o counts 0..N-1, with each value held for S cycles. chip_first_o is high only on the first cycle of each chip, and freq_word_o is constant within a chip.
- R4: pulse_done_o is high for exactly one cycle, which is the cycle right after the last sample of the last chip. chip_valid_o is low in that cycle.
- R5: Chip j uses slot 0 when j mod 2^SLOT_BITS is 0. Otherwise it uses the next state of a shift register that is loaded with the seed at start. The register shifts left and inserts the XOR of the tapped bits as its LSB; the default is 6 bits with taps on bits 5 and 4. The register advances only after a nonzero slot has used it. As a result, each group of 64 chips uses all 64 slots once.
- R6: The frequency word of a chip is base_freq + slot*freq_step, taken modulo 2^32, with no saturation.
- R7: With phase_reload_i low at start, phase_load_o pulses only at chip 0. With it high, phase_load_o pulses on the first cycle of every chip.
- R8: A start strobe during an active pulse aborts that pulse and restarts at chip 0 with the shift register reseeded. This includes a start strobe on the last sample. The aborted pulse never raises pulse_done_o.
- R9: A configuration with N=0, S=0 or S not a power of two is invalid. An invalid start is ignored when the block is idle. When a pulse is active, an invalid start stops it with no pulse_done_o.
- R10: A seed of zero is replaced by 1.
- R11: Configuration inputs are captured at start. Changes to them during a pulse have no effect on that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse start strobe |
| cfg_chips_i | input | 32 | Chip count [31:16], samples per chip [15:0] |
| base_freq_i | input | 32 | Frequency word of slot 0 |
| freq_step_i | input | 32 | Frequency increment per slot |
| seed_i | input | 6 | Shuffle register seed |
| start_phase_i | input | 32 | Start-phase word |
| phase_reload_i | input | 1 | Reload phase at every chip boundary |
| freq_word_o | output | 32 | Frequency increment for the current chip |
| phase_word_o | output | 32 | Phase word to load |
| phase_load_o | output | 1 | Phase-load strobe |
| chip_index_o | output | 16 | Current chip number |
| chip_valid_o | output | 1 | High on every sample of a pulse |
| chip_first_o | output | 1 | High on the first sample of each chip |
| pulse_done_o | output | 1 | One-cycle end-of-pulse strobe |

## Verification
The sharpest collision happens when a new start strobe lands on the very cycle that holds the last sample of the last chip. In that cycle the pulse would normally end and raise its done strobe, and a restart at the same time must suppress that strobe. The bench provokes this by stopping its sample-by-sample check at that exact cycle and raising start. It then requires that the following cycle shows chip 0 of the new pulse with no done strobe. A second overlap is the chip boundary that reinserts slot 0 after 63 shuffled chips: there the shift register must hold still while the chip counter advances. The bench judges that boundary against its own model over a 66-chip pulse.

// File: rtl/chs_pkg.sv
// Shared definitions for the chip hop sequencer.
// Assumes shift-register widths between 3 and 8 bits for the tap table.
package chs_pkg;

    // Packed chip configuration: chip count above, samples per chip below.
    typedef struct packed {
        logic [15:0] chips;
        logic [15:0] spc;
    } chip_cfg_t;

    // Tap mask of a maximal-length left-shifting register of width k.
    function automatic logic [15:0] lfsr_tap_mask(input int k);
        logic [15:0] m;
        case (k)
            3:       m = 16'h0006;
            4:       m = 16'h000C;
            5:       m = 16'h0014;
            6:       m = 16'h0030;
            7:       m = 16'h0060;
            8:       m = 16'h00B8;
            default: m = 16'h0030;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hop_lfsr.sv
// Seeded left-shifting feedback register used to shuffle frequency slots.
// Loads the seed (zero replaced by 1) on load; steps on advance.
// Assumes SLOT_BITS is a width covered by the package tap table.
module hop_lfsr #(
    parameter int SLOT_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [SLOT_BITS-1:0] seed,
    input  logic                 advance,
    output logic [SLOT_BITS-1:0] state
);
    localparam logic [15:0]          TAPS_FULL = chs_pkg::lfsr_tap_mask(SLOT_BITS);
    localparam logic [SLOT_BITS-1:0] TAPS      = TAPS_FULL[SLOT_BITS-1:0];
    localparam logic [SLOT_BITS-1:0] ONE       = {{(SLOT_BITS-1){1'b0}}, 1'b1};

    logic feedback;

    // Feedback bit is the parity of the tapped positions.
    always_comb feedback = ^(state & TAPS);

    // Load, step or hold the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ONE;
        end else if (load) begin
            state <= (seed == '0) ? ONE : seed;
        end else if (advance) begin
            state <= {state[SLOT_BITS-2:0], feedback};
        end
    end
endmodule

// File: rtl/hop_timer.sv
// Sample and chip counters of one pulse.
// go restarts at chip 0; kill stops without an end event.
// Assumes spc and nch are held steady while active.
module hop_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             kill,
    input  logic [CNT_W-1:0] spc,
    input  logic [CNT_W-1:0] nch,
    output logic             active,
    output logic [CNT_W-1:0] chip_cnt,
    output logic             chip_adv,
    output logic             pulse_end
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] samp_cnt;
    logic             samp_last;
    logic             chip_last;
    logic             quiet;

    // Boundary detection for the current sample and chip.
    always_comb begin
        samp_last = active && (samp_cnt == spc - ONE);
        chip_last = (chip_cnt == nch - ONE);
        quiet     = !go && !kill;
        chip_adv  = samp_last && !chip_last && quiet;
        pulse_end = samp_last && chip_last && quiet;
    end

    // Counter state: restart, stop or step through samples and chips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            samp_cnt <= '0;
            chip_cnt <= '0;
        end else if (go) begin
            active   <= 1'b1;
            samp_cnt <= '0;
            chip_cnt <= '0;
        end else if (kill) begin
            active   <= 1'b0;
        end else if (active) begin
            if (samp_last) begin
                samp_cnt <= '0;
                if (chip_last) begin
                    active   <= 1'b0;
                end else begin
                    chip_cnt <= chip_cnt + ONE;
                end
            end else begin
                samp_cnt <= samp_cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/hop_freq_calc.sv
// Combinational chip frequency: base + slot * step, modulo 2^FW.
// USE_MULT selects a plain product or an unrolled shift-add sum.
module hop_freq_calc #(
    parameter int FW        = 32,
    parameter int SLOT_BITS = 6,
    parameter bit USE_MULT  = 1'b1
) (
    input  logic [FW-1:0]        base,
    input  logic [FW-1:0]        step,
    input  logic [SLOT_BITS-1:0] slot,
    output logic [FW-1:0]        freq
);
    logic [FW-1:0] offset;

    generate
        if (USE_MULT) begin : g_mult
            logic [FW-1:0] slot_ext;
            // Product truncated to the accumulator width.
            always_comb begin
                slot_ext = {{(FW-SLOT_BITS){1'b0}}, slot};
                offset   = step * slot_ext;
            end
        end else begin : g_shadd
            logic [FW-1:0] part [SLOT_BITS];
            for (genvar b = 0; b < SLOT_BITS; b++) begin : g_part
                // One shifted copy of the step per slot bit.
                always_comb part[b] = slot[b] ? (step << b) : '0;
            end
            // Sum of the selected partial products.
            always_comb begin
                offset = '0;
                for (int b = 0; b < SLOT_BITS; b++) offset = offset + part[b];
            end
        end
    endgenerate

    // Final offset onto the base frequency.
    always_comb freq = base + offset;
endmodule

// File: rtl/chip_hop_sequencer.sv
// Frequency-hopped chip sequencer. On a valid start it captures the
// configuration and emits, per chip, a frequency word from a shuffled
// slot, plus phase-load strobes. Outputs are registered; freq_word_o
// changes on the cycle chip_first_o marks a new chip and holds after
// the pulse. Assumes CNT_W >= SLOT_BITS.
module chip_hop_sequencer #(
    parameter int FW        = 32,
    parameter int CNT_W     = 16,
    parameter int SLOT_BITS = 6,
    parameter bit USE_MULT  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2*CNT_W-1:0]   cfg_chips_i,
    input  logic [FW-1:0]        base_freq_i,
    input  logic [FW-1:0]        freq_step_i,
    input  logic [SLOT_BITS-1:0] seed_i,
    input  logic [FW-1:0]        start_phase_i,
    input  logic                 phase_reload_i,
    output logic [FW-1:0]        freq_word_o,
    output logic [FW-1:0]        phase_word_o,
    output logic                 phase_load_o,
    output logic [CNT_W-1:0]     chip_index_o,
    output logic                 chip_valid_o,
    output logic                 chip_first_o,
    output logic                 pulse_done_o
);
    localparam logic [CNT_W-1:0]     CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [SLOT_BITS-1:0] SLOT_ONE = {{(SLOT_BITS-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]     cfg_n, cfg_s;
    logic                 cfg_ok, go, kill;
    logic [CNT_W-1:0]     nch_q, spc_q;
    logic [FW-1:0]        base_q, step_q;
    logic                 reload_q;
    logic                 active, chip_adv, pulse_end;
    logic [CNT_W-1:0]     chip_cnt;
    logic [SLOT_BITS-1:0] next_pos, lfsr_state, slot_next;
    logic                 lfsr_adv;
    logic [FW-1:0]        freq_next;

    // Split and qualify the incoming configuration word.
    always_comb begin
        cfg_n  = cfg_chips_i[2*CNT_W-1:CNT_W];
        cfg_s  = cfg_chips_i[CNT_W-1:0];
        cfg_ok = (cfg_n != '0) && (cfg_s != '0) && ((cfg_s & (cfg_s - CNT_ONE)) == '0);
        go     = start_i && cfg_ok;
        kill   = start_i && !cfg_ok;
    end

    // Capture the pulse configuration at a valid start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nch_q    <= '0;
            spc_q    <= '0;
            base_q   <= '0;
            step_q   <= '0;
            reload_q <= 1'b0;
        end else if (go) begin
            nch_q    <= cfg_n;
            spc_q    <= cfg_s;
            base_q   <= base_freq_i;
            step_q   <= freq_step_i;
            reload_q <= phase_reload_i;
        end
    end

    hop_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .kill     (kill),
        .spc      (spc_q),
        .nch      (nch_q),
        .active   (active),
        .chip_cnt (chip_cnt),
        .chip_adv (chip_adv),
        .pulse_end(pulse_end)
    );

    // Slot of the next chip: 0 at the start of each slot group, else the shuffle state.
    always_comb begin
        next_pos  = chip_cnt[SLOT_BITS-1:0] + SLOT_ONE;
        slot_next = (next_pos == '0) ? '0 : lfsr_state;
        lfsr_adv  = chip_adv && (next_pos != '0);
    end

    hop_lfsr #(
        .SLOT_BITS(SLOT_BITS)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (go),
        .seed   (seed_i),
        .advance(lfsr_adv),
        .state  (lfsr_state)
    );

    hop_freq_calc #(
        .FW       (FW),
        .SLOT_BITS(SLOT_BITS),
        .USE_MULT (USE_MULT)
    ) u_freq (
        .base(base_q),
        .step(step_q),
        .slot(slot_next),
        .freq(freq_next)
    );

    // Registered chip words and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_word_o  <= '0;
            phase_word_o <= '0;
            phase_load_o <= 1'b0;
            chip_first_o <= 1'b0;
            pulse_done_o <= 1'b0;
        end else begin
            chip_first_o <= go || chip_adv;
            phase_load_o <= go || (chip_adv && reload_q);
            pulse_done_o <= pulse_end;
            if (go) begin
                freq_word_o  <= base_freq_i;
                phase_word_o <= start_phase_i;
            end else if (chip_adv) begin
                freq_word_o  <= freq_next;
            end
        end
    end

    // Counter state seen directly at the ports.
    always_comb begin
        chip_valid_o = active;
        chip_index_o = chip_cnt;
    end
endmodule

// File: rtl/chip_hop_sequencer_chk.sv
// Temporal checks on the sequencer ports, bound to every instance.
module chip_hop_sequencer_chk #(
    parameter int FW    = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [FW-1:0]    freq_word_o,
    input logic             phase_load_o,
    input logic [CNT_W-1:0] chip_index_o,
    input logic             chip_valid_o,
    input logic             chip_first_o,
    input logic             pulse_done_o
);
    assert_first_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chip_first_o |-> chip_valid_o);

    assert_freq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid_o && !chip_first_o) |-> $stable(freq_word_o));

    assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_first_o && !$past(start_i)) |-> (chip_index_o == CNT_W'($past(chip_index_o) + 1'b1)));

    assert_done_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done_o |-> (!chip_valid_o && $past(chip_valid_o)));

    assert_load_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_load_o |-> chip_first_o);

    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i) && chip_first_o) |-> (chip_index_o == '0));

    assert_no_done_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !pulse_done_o);
endmodule

bind chip_hop_sequencer chip_hop_sequencer_chk #(
    .FW   (FW),
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .freq_word_o (freq_word_o),
    .phase_load_o(phase_load_o),
    .chip_index_o(chip_index_o),
    .chip_valid_o(chip_valid_o),
    .chip_first_o(chip_first_o),
    .pulse_done_o(pulse_done_o)
);

// File: tb/tb_chip_hop_sequencer.sv
module tb_chip_hop_sequencer;
    localparam time TCK = 4ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] cfg_chips_i;
    logic [31:0] base_freq_i, freq_step_i, start_phase_i;
    logic [5:0]  seed_i;
    logic        phase_reload_i;
    logic [31:0] freq_word_o, phase_word_o;
    logic        phase_load_o, chip_valid_o, chip_first_o, pulse_done_o;
    logic [15:0] chip_index_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(TCK/2) clk = ~clk;

    chip_hop_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_chips_i(cfg_chips_i),
        .base_freq_i(base_freq_i), .freq_step_i(freq_step_i), .seed_i(seed_i),
        .start_phase_i(start_phase_i), .phase_reload_i(phase_reload_i),
        .freq_word_o(freq_word_o), .phase_word_o(phase_word_o), .phase_load_o(phase_load_o),
        .chip_index_o(chip_index_o), .chip_valid_o(chip_valid_o),
        .chip_first_o(chip_first_o), .pulse_done_o(pulse_done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] lfsr_next(input logic [5:0] s);
        return {s[4:0], s[5] ^ s[4]};
    endfunction

    task automatic start_pulse(input int n, input int spc, input logic [31:0] fb, input logic [31:0] fs,
                               input logic [5:0] seed, input bit reload, input logic [31:0] ph);
        cfg_chips_i    = {n[15:0], spc[15:0]};
        base_freq_i    = fb;
        freq_step_i    = fs;
        seed_i         = seed;
        phase_reload_i = reload;
        start_phase_i  = ph;
        start_i        = 1'b1;
        @(negedge clk);
        start_i        = 1'b0;
    endtask

    // Walks a pulse sample by sample from the current negedge; stop_after<0 runs to the end.
    task automatic check_pulse(input int n, input int spc, input logic [31:0] fb, input logic [31:0] fs,
                               input logic [5:0] seed, input bit reload, input logic [31:0] ph,
                               input int stop_after);
        logic [5:0]  lf;
        logic [5:0]  slot;
        logic [31:0] ef;
        int cnt = 0;
        lf = (seed == 6'd0) ? 6'd1 : seed;
        for (int j = 0; j < n; j++) begin
            slot = (j % 64 == 0) ? 6'd0 : lf;
            ef   = fb + fs * {26'd0, slot};
            for (int s = 0; s < spc; s++) begin
                if (cnt == stop_after) return;
                chk(chip_valid_o == 1'b1, "R3 valid", {31'd0, chip_valid_o}, 32'd1);
                chk(chip_index_o == j[15:0], "R3 index", {16'd0, chip_index_o}, j);
                chk(chip_first_o == (s == 0), "R3 first", {31'd0, chip_first_o}, {31'd0, s == 0});
                chk(freq_word_o == ef, "R5/R6 freq", freq_word_o, ef);
                chk(phase_load_o == (s == 0 && (j == 0 || reload)), "R7 load",
                    {31'd0, phase_load_o}, {31'd0, (s == 0 && (j == 0 || reload))});
                chk(phase_word_o == ph, "R2 phase", phase_word_o, ph);
                chk(pulse_done_o == 1'b0, "R4 early done", {31'd0, pulse_done_o}, 32'd0);
                cnt++;
                @(negedge clk);
            end
            if (j % 64 != 0) lf = lfsr_next(lf);
        end
        chk(pulse_done_o == 1'b1, "R4 done", {31'd0, pulse_done_o}, 32'd1);
        chk(chip_valid_o == 1'b0, "R4 valid low", {31'd0, chip_valid_o}, 32'd0);
        @(negedge clk);
        chk(pulse_done_o == 1'b0, "R4 single", {31'd0, pulse_done_o}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start_i = 1'b0; cfg_chips_i = '0; base_freq_i = '0; freq_step_i = '0;
        seed_i = '0; start_phase_i = '0; phase_reload_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(freq_word_o == 0 && phase_word_o == 0 && chip_index_o == 0, "R1 words", freq_word_o, 0);
        chk(!chip_valid_o && !chip_first_o && !phase_load_o && !pulse_done_o, "R1 strobes",
            {28'd0, chip_valid_o, chip_first_o, phase_load_o, pulse_done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!chip_valid_o && freq_word_o == 0, "R1 after release", {31'd0, chip_valid_o}, 0);
    endtask

    task automatic t_basic;  // R2 R3 R5 R6
        start_pulse(5, 4, 32'd1000, 32'd28633115, 6'd2, 1'b0, 32'h1234_5678);
        chk(chip_first_o && freq_word_o == 32'd1000, "R2 first chip", freq_word_o, 32'd1000);
        check_pulse(5, 4, 32'd1000, 32'd28633115, 6'd2, 1'b0, 32'h1234_5678, -1);
    endtask

    task automatic t_reload;  // R7
        start_pulse(3, 2, 32'd50, 32'd7, 6'd9, 1'b1, 32'hCAFE_0001);
        check_pulse(3, 2, 32'd50, 32'd7, 6'd9, 1'b1, 32'hCAFE_0001, -1);
    endtask

    task automatic t_permutation;  // R5
        bit [63:0] seen = '0;
        int distinct = 0;
        start_pulse(64, 1, 32'd0, 32'd1, 6'd37, 1'b0, 32'd0);
        for (int i = 0; i < 64; i++) begin
            seen[freq_word_o[5:0]] = 1'b1;
            @(negedge clk);
        end
        for (int i = 0; i < 64; i++) distinct += seen[i];
        chk(distinct == 64, "R5 all slots once", distinct, 64);
        chk(pulse_done_o == 1'b1, "R4 done after 64", {31'd0, pulse_done_o}, 1);
        @(negedge clk);
        start_pulse(66, 1, 32'd0, 32'd1, 6'd37, 1'b0, 32'd0);
        check_pulse(66, 1, 32'd0, 32'd1, 6'd37, 1'b0, 32'd0, -1);
    endtask

    task automatic t_wrap;  // R6
        start_pulse(4, 2, 32'hFFFF_FF00, 32'h8000_0001, 6'd5, 1'b0, 32'd3);
        check_pulse(4, 2, 32'hFFFF_FF00, 32'h8000_0001, 6'd5, 1'b0, 32'd3, -1);
    endtask

    task automatic t_invalid_idle;  // R9
        int bad = 0;
        start_pulse(4, 3, 32'd1, 32'd1, 6'd1, 1'b0, 32'd0);
        repeat (4) begin
            if (chip_valid_o || chip_first_o || pulse_done_o) bad++;
            @(negedge clk);
        end
        start_pulse(0, 4, 32'd1, 32'd1, 6'd1, 1'b0, 32'd0);
        repeat (4) begin
            if (chip_valid_o || chip_first_o || pulse_done_o) bad++;
            @(negedge clk);
        end
        start_pulse(4, 0, 32'd1, 32'd1, 6'd1, 1'b0, 32'd0);
        repeat (4) begin
            if (chip_valid_o || chip_first_o || pulse_done_o) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9 invalid start ignored", bad, 0);
    endtask

    task automatic t_abort;  // R8
        start_pulse(4, 4, 32'd10, 32'd3, 6'd11, 1'b0, 32'd1);
        check_pulse(4, 4, 32'd10, 32'd3, 6'd11, 1'b0, 32'd1, 5);
        start_pulse(3, 2, 32'd500, 32'd9, 6'd20, 1'b0, 32'd2);
        chk(chip_index_o == 0 && chip_first_o, "R8 abort restarts", {16'd0, chip_index_o}, 0);
        check_pulse(3, 2, 32'd500, 32'd9, 6'd20, 1'b0, 32'd2, -1);
    endtask

    task automatic t_last_sample_restart;  // R8
        start_pulse(2, 2, 32'd77, 32'd5, 6'd3, 1'b0, 32'd4);
        check_pulse(2, 2, 32'd77, 32'd5, 6'd3, 1'b0, 32'd4, 3);
        chk(chip_index_o == 1 && chip_valid_o, "R8 on last sample", {16'd0, chip_index_o}, 1);
        start_pulse(2, 1, 32'd900, 32'd2, 6'd4, 1'b0, 32'd6);
        chk(pulse_done_o == 1'b0, "R8 no done on restart", {31'd0, pulse_done_o}, 0);
        check_pulse(2, 1, 32'd900, 32'd2, 6'd4, 1'b0, 32'd6, -1);
    endtask

    task automatic t_invalid_active;  // R9
        int bad = 0;
        start_pulse(4, 4, 32'd1, 32'd1, 6'd1, 1'b0, 32'd0);
        check_pulse(4, 4, 32'd1, 32'd1, 6'd1, 1'b0, 32'd0, 3);
        start_pulse(0, 0, 32'd1, 32'd1, 6'd1, 1'b0, 32'd0);
        chk(chip_valid_o == 1'b0, "R9 invalid start stops", {31'd0, chip_valid_o}, 0);
        repeat (20) begin
            if (pulse_done_o || chip_valid_o) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9 no done after stop", bad, 0);
    endtask

    task automatic t_seed_zero;  // R10
        start_pulse(4, 1, 32'd0, 32'd1, 6'd0, 1'b0, 32'd0);
        check_pulse(4, 1, 32'd0, 32'd1, 6'd1, 1'b0, 32'd0, -1);
    endtask

    task automatic t_cfg_capture;  // R11
        start_pulse(3, 2, 32'd100, 32'd10, 6'd7, 1'b0, 32'hABCD);
        cfg_chips_i = {16'd9, 16'd1}; base_freq_i = 32'd5; freq_step_i = 32'd99;
        seed_i = 6'd60; phase_reload_i = 1'b1; start_phase_i = 32'd1;
        check_pulse(3, 2, 32'd100, 32'd10, 6'd7, 1'b0, 32'hABCD, -1);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_reload();
        t_permutation();
        t_wrap();
        t_invalid_idle();
        t_abort();
        t_last_sample_restart();
        t_invalid_active();
        t_seed_zero();
        t_cfg_capture();
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(TCK * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at %0t", $time);
            report();
            $finish;
        end
    end
endmodule